// File: doc/BRIEF.md
# Two-Phase Bundled-Data Latch Pipeline

This block is a chain of pipeline stages that pass data using transition signalling. A sender and a receiver talk to it through a request/acknowledge pair at each end. A request edge of either polarity announces one data word. An acknowledge edge of either polarity frees the slot that word held. No return-to-zero phase is needed.

Each stage holds a request bit and a data word. Its capture enable is the equality of its own request bit and the acknowledge from its successor, which is the successor's request bit, or the external acknowledge for the final stage. While the two are equal the stage is open and copies its predecessor. Once a new request has entered, they differ and the stage is closed until the successor takes the word.

For simulation and timing closure, transparency is sampled on a clock: each open stage copies its input once per rising edge. A token therefore moves one stage per clock.

Top module: `tsig_pipe`

## Requirements
- R1: While `rst_n` is low, every request bit and data word is cleared, so `in_ack`, `out_req` and `out_data` read 0 from the first edge after reset is asserted.
- R2: On an empty pipeline, a toggle of `in_req` with a word on `in_data` makes `out_req` toggle exactly STAGES rising edges later, with that word on `out_data`.
- R3: Rising and falling edges of `in_req` each carry one word. Two consecutive tokens of opposite polarity both traverse the pipeline.
- R4: `in_ack` changes only to copy the level `in_req` had at the previous edge. On an empty pipeline it matches `in_req` one edge after the toggle.
- R5: While `out_req` differs from `out_ack`, both `out_req` and `out_data` hold their values.
- R6: With `out_ack` frozen, exactly STAGES tokens are accepted. A further `in_req` toggle leaves `in_ack` unequal to `in_req`.
- R7: Under random sender and receiver delays, at least 64 words leave in the order they entered, with none lost or repeated.
- R8: In a full pipeline, an `out_ack` toggle and a new `in_req` toggle in the same cycle are both honoured. The freed slot travels back one stage per edge, so `in_ack` matches `in_req` exactly STAGES edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for latch transparency |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_req | input | 1 | Sender request; each edge announces a word |
| in_data | input | W | Word bundled with `in_req` |
| in_ack | output | 1 | Acknowledge to sender (first stage's request bit) |
| out_req | output | 1 | Request to receiver (last stage's request bit) |
| out_data | output | W | Word bundled with `out_req` |
| out_ack | input | 1 | Receiver acknowledge; each edge frees the last stage |

## Verification
Two things can happen in the same cycle: the receiver releases the final stage, and the sender offers a new word. The bench fills the pipeline, then toggles `out_ack` and `in_req` on the same falling clock edge. It counts edges until `in_ack` catches up, and expects exactly STAGES. It then drains every word and checks that the order is unchanged. The random phase produces the same coincidence by chance at many pipeline depths. A queue model checks `out_data` on every clock at which a word is offered.

// File: rtl/tsig_pipe.sv
module tsig_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_req,
  input  logic [W-1:0] in_data,
  output logic         in_ack,
  output logic         out_req,
  output logic [W-1:0] out_data,
  input  logic         out_ack
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] req_q;
  logic [STAGES-1:0] req_up;
  logic [STAGES-1:0] ack_dn;
  logic [STAGES-1:0] open_st;
  logic [W-1:0]      dat_q  [STAGES];
  logic [W-1:0]      dat_up [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_head
      assign req_up[i] = in_req;
      assign dat_up[i] = in_data;
    end else begin : g_body
      assign req_up[i] = req_q[i-1];
      assign dat_up[i] = dat_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign ack_dn[i] = out_ack;
    end else begin : g_mid
      assign ack_dn[i] = req_q[i+1];
    end

    // open while no unacknowledged token is held
    assign open_st[i] = ~(req_q[i] ^ ack_dn[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i] <= 1'b0;
        dat_q[i] <= '0;
      end else if (open_st[i]) begin
        req_q[i] <= req_up[i];
        dat_q[i] <= dat_up[i];
      end
    end
  end

  assign in_ack   = req_q[0];
  assign out_req  = req_q[LAST];
  assign out_data = dat_q[LAST];
endmodule

// File: rtl/tsig_pipe_chk.sv
module tsig_pipe_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_req,
  input logic         in_ack,
  input logic         out_req,
  input logic [W-1:0] out_data,
  input logic         out_ack
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!in_ack && !out_req && out_data == '0));

  assert_ack_copies_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ack) |-> (in_ack == $past(in_req)));

  assert_idle_ack_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack == in_req) |=> $stable(in_ack));

  assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req != out_ack) |=> $stable(out_req));

  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req != out_ack) |=> $stable(out_data));
endmodule

bind tsig_pipe tsig_pipe_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
  .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
);

// File: tb/tsig_pipe_test.sv
module tsig_pipe_test;
  localparam int W = 8;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ack;
  logic         out_req;
  logic [W-1:0] out_data;
  logic         out_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];

  always #4 clk = ~clk;

  tsig_pipe #(.W(W), .STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
  );

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // reference model: the oldest unacknowledged word must be offered
  always @(posedge clk) begin
    if (rst_n && !finished && out_req != out_ack && exp_q.size() > 0)
      check(out_data == exp_q[0], "R7 model", out_data, exp_q[0]);
  end

  task automatic drive(input logic [W-1:0] d);
    in_data = d;
    in_req  = ~in_req;
    exp_q.push_back(d);
  endtask

  task automatic send(input logic [W-1:0] d);
    @(negedge clk);
    while (in_ack != in_req) @(negedge clk);
    drive(d);
  endtask

  task automatic recv(input string r);
    @(negedge clk);
    while (out_req == out_ack) @(negedge clk);
    check(exp_q.size() > 0 && out_data == exp_q[0], r, out_data,
          exp_q.size() > 0 ? int'(exp_q[0]) : -1);
    void'(exp_q.pop_front());
    out_ack = ~out_ack;
  endtask

  task automatic latency(input logic [W-1:0] d, input string r);
    logic start;
    int cnt;
    start = out_req;
    @(negedge clk);
    drive(d);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) check(in_ack == in_req, "R4 single-edge accept", in_ack, in_req);
    end while (out_req == start && cnt < 50);
    check(cnt == N, r, cnt, N);
    check(out_data == d, r, out_data, d);
    recv(r);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(in_ack == 1'b0, "R1 in_ack", in_ack, 0);
    check(out_req == 1'b0, "R1 out_req", out_req, 0);
    check(out_data == '0, "R1 out_data", out_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    latency(8'hA5, "R2 rising token");
    latency(8'h3C, "R3 falling token");

    // R6: capacity with receiver stalled
    for (int k = 0; k < N; k++) send(8'h10 + 8'(k));
    repeat (2 * N) @(negedge clk);
    check(in_ack == in_req, "R6 holds STAGES tokens", in_ack, in_req);
    drive(8'h20);
    repeat (2 * N) @(negedge clk);
    check(in_ack != in_req, "R6 extra token refused", in_ack, ~in_req);
    for (int k = 0; k <= N; k++) recv("R6 drain order");

    // R8: release and new request on the same edge of a full pipe
    for (int k = 0; k < N; k++) send(8'h40 + 8'(k));
    repeat (2 * N) @(negedge clk);
    check(in_ack == in_req, "R8 pipe full", in_ack, in_req);
    @(negedge clk);
    check(out_data == exp_q[0], "R8 head before release", out_data, exp_q[0]);
    void'(exp_q.pop_front());
    out_ack = ~out_ack;
    drive(8'h55);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (in_ack != in_req && cnt < 50);
    check(cnt == N, "R8 bubble return edges", cnt, N);
    for (int k = 0; k < N; k++) recv("R8 drain order");

    // R7: random delays at both ends
    fork
      begin
        for (int k = 0; k < 100; k++) begin
          repeat ($urandom % 4) @(negedge clk);
          send(8'(k * 7 + 1));
        end
      end
      begin
        for (int k = 0; k < 100; k++) begin
          repeat ($urandom % 5) @(negedge clk);
          recv("R7 random order");
        end
      end
    join
    repeat (2 * N) @(negedge clk);
    check(exp_q.size() == 0, "R7 nothing left", exp_q.size(), 0);
    check(out_req == out_ack, "R7 no duplicate offer", out_req, out_ack);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule